// File: doc/BRIEF.md
# Receiver Fault Flag and Output Silencing Controller

This block sits beside the stream decoder of an optical multichannel audio receiver. It watches the decoder's lock indication and raises a fault flag whenever the stream is missing or the decoder cannot follow it. The same flag silences the serial audio data. A separate set of clock copies is gated by the fault flag, so converters fed from those copies never see a clock running at an uncontrolled rate. The primary clocks are not touched. An optional sticky mode holds the flag until software or board logic has seen it.

A software-style mute input silences data whatever the fault state. A clear-down request forces the fault state, stopping the gated clocks and muting data. It stands for the format code that resets the receiver.

The block also counts word-clock periods of uninterrupted lock. It asserts a settled flag once enough have passed for output timing to be guaranteed.

Top module: `rx_fault_ctrl`

## Requirements
- R1: One clock after `lock_i` is low or `clr_req_i` is high at a rising edge, `fault_o` is high.
- R2: With `hold_i` low, `fault_o` follows the fault condition: one clock after an edge with `lock_i` high and `clr_req_i` low, `fault_o` is low.
- R3: With `hold_i` high, a raised `fault_o` stays high. It falls one clock after the first edge where the fault condition is absent and `hold_i` is low.
- R4: `dmute_o` is high whenever `fault_o` is high.
- R5: One clock after `mute_i` is high at an edge, `dmute_o` is high, regardless of the fault state.
- R6: Each bit of `gclk_o` equals the same bit of `clk_src_i` ANDed with the inverse of `fault_o`.
- R7: `clr_req_i` high raises `fault_o`, mutes data, stops every `gclk_o` bit and clears the settle count.
- R8: `settled_o` rises on the clock after the SETTLE_CYCLES-th `wclk_tick_i` pulse counted since the last fault-free restart. It is low before that pulse.
- R9: Any edge with the fault condition present clears the settle count, so `settled_o` is low one clock later. Further ticks after settling keep `settled_o` high, because the count saturates.
- R10: While `rst_n` is low, and after it until lock is first reported, `fault_o` and `dmute_o` are high, `settled_o` is low and `gclk_o` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lock_i | input | 1 | Decoder reports a valid, synchronized stream |
| hold_i | input | 1 | Sticky-fault enable |
| mute_i | input | 1 | Forces data silence |
| clr_req_i | input | 1 | Receiver clear-down request |
| wclk_tick_i | input | 1 | One-cycle pulse per word-clock period |
| clk_src_i | input | NUM_GCLK | Clocks to be fault-gated |
| fault_o | output | 1 | Fault flag |
| dmute_o | output | 1 | Data-mute enable for the serializers |
| gclk_o | output | NUM_GCLK | Fault-gated copies of clk_src_i |
| settled_o | output | 1 | Output timing guaranteed |

## Verification
The bench builds the block with SETTLE_CYCLES set to 12 and NUM_GCLK set to 2. With the short settle window, the exact rising cycle of the settled flag, its saturation and its clearing on lock loss all fall within a few dozen cycles. Random traffic with lock mostly held then reaches the settled state many times. Two gated clocks show that each bit is gated independently. The full-size window uses the same counter logic at a wider width.

// File: rtl/rx_fault_pkg.sv
package rx_fault_pkg;

    typedef struct packed {
        logic fault;
        logic dmute;
    } flag_st_t;

endpackage

// File: rtl/rx_fault_latch.sv
module rx_fault_latch
    import rx_fault_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic hold_i,
    input  logic mute_i,
    output logic fault_o,
    output logic dmute_o
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        // sticky only while hold is asserted; otherwise track the cause
        st_d.fault = cause_i | (st_q.fault & hold_i);
        st_d.dmute = st_d.fault | mute_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{fault: 1'b1, dmute: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_o = st_q.fault;
    assign dmute_o = st_q.dmute;

endmodule

// File: rtl/rx_settle_cnt.sv
module rx_settle_cnt #(
    parameter int unsigned SETTLE_CYCLES = 3900
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cause_i,
    input  logic tick_i,
    output logic settled_o
);

    localparam int unsigned CW = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CW-1:0] TERM = CW'(SETTLE_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != TERM)) begin
            st_d.cnt = st_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign settled_o = (st_q.cnt == TERM);

endmodule

// File: rtl/rx_clk_gate.sv
module rx_clk_gate #(
    parameter int unsigned NUM_GCLK = 2
) (
    input  logic [NUM_GCLK-1:0] clk_src_i,
    input  logic                fault_i,
    output logic [NUM_GCLK-1:0] gclk_o
);

    for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gate
        assign gclk_o[g] = clk_src_i[g] & ~fault_i;
    end

endmodule

// File: rtl/rx_fault_ctrl.sv
module rx_fault_ctrl #(
    parameter int unsigned SETTLE_CYCLES = 3900,
    parameter int unsigned NUM_GCLK      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                lock_i,
    input  logic                hold_i,
    input  logic                mute_i,
    input  logic                clr_req_i,
    input  logic                wclk_tick_i,
    input  logic [NUM_GCLK-1:0] clk_src_i,
    output logic                fault_o,
    output logic                dmute_o,
    output logic [NUM_GCLK-1:0] gclk_o,
    output logic                settled_o
);

    logic cause;

    assign cause = ~lock_i | clr_req_i;

    rx_fault_latch i_latch (
        .clk     (clk),
        .rst_n   (rst_n),
        .cause_i (cause),
        .hold_i  (hold_i),
        .mute_i  (mute_i),
        .fault_o (fault_o),
        .dmute_o (dmute_o)
    );

    rx_settle_cnt #(.SETTLE_CYCLES(SETTLE_CYCLES)) i_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .cause_i   (cause),
        .tick_i    (wclk_tick_i),
        .settled_o (settled_o)
    );

    rx_clk_gate #(.NUM_GCLK(NUM_GCLK)) i_gate (
        .clk_src_i (clk_src_i),
        .fault_i   (fault_o),
        .gclk_o    (gclk_o)
    );

endmodule

// File: rtl/rx_fault_ctrl_chk.sv
module rx_fault_ctrl_chk #(
    parameter int unsigned NUM_GCLK = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                lock_i,
    input logic                hold_i,
    input logic                mute_i,
    input logic                clr_req_i,
    input logic [NUM_GCLK-1:0] clk_src_i,
    input logic                fault_o,
    input logic                dmute_o,
    input logic [NUM_GCLK-1:0] gclk_o,
    input logic                settled_o
);

    // R1
    cause_raises_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i || clr_req_i) |=> fault_o);

    // R2
    release_clears_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_i && !clr_req_i && !hold_i) |=> !fault_o);

    // R3
    hold_keeps_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_o && hold_i) |=> fault_o);

    // R4
    fault_mutes_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> dmute_o);

    // R5
    mute_forces_silence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mute_i |=> dmute_o);

    // R6
    gated_clk_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (gclk_o == '0));

    // R6
    gated_clk_passes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (gclk_o == clk_src_i));

    // R9
    lock_loss_unsettles_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lock_i || clr_req_i) |=> !settled_o);

endmodule

bind rx_fault_ctrl rx_fault_ctrl_chk #(.NUM_GCLK(NUM_GCLK)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_i    (lock_i),
    .hold_i    (hold_i),
    .mute_i    (mute_i),
    .clr_req_i (clr_req_i),
    .clk_src_i (clk_src_i),
    .fault_o   (fault_o),
    .dmute_o   (dmute_o),
    .gclk_o    (gclk_o),
    .settled_o (settled_o)
);

// File: tb/test_rx_fault_ctrl.sv
module test_rx_fault_ctrl;

    localparam int unsigned SETTLE = 12;
    localparam int unsigned NG     = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          lock_i = 1'b0, hold_i = 1'b0, mute_i = 1'b0, clr_req_i = 1'b0, wclk_tick_i = 1'b0;
    logic [NG-1:0] clk_src_i = '0;
    logic          fault_o, dmute_o, settled_o;
    logic [NG-1:0] gclk_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // model state
    bit exp_fault = 1'b1;
    bit exp_dmute = 1'b1;
    int exp_cnt   = 0;

    always #2.5 clk = ~clk;

    rx_fault_ctrl #(.SETTLE_CYCLES(SETTLE), .NUM_GCLK(NG)) i_rx_fault_ctrl (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .hold_i(hold_i), .mute_i(mute_i),
        .clr_req_i(clr_req_i), .wclk_tick_i(wclk_tick_i), .clk_src_i(clk_src_i),
        .fault_o(fault_o), .dmute_o(dmute_o), .gclk_o(gclk_o), .settled_o(settled_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic int exp_gclk(input logic [NG-1:0] src, input bit f);
        return f ? 0 : int'(src);
    endfunction

    task automatic check_all();
        check("R1/R2/R3 fault_o", int'(fault_o), int'(exp_fault));
        check("R4/R5 dmute_o", int'(dmute_o), int'(exp_dmute));
        check("R6 gclk_o", int'(gclk_o), exp_gclk(clk_src_i, exp_fault));
        check("R8/R9 settled_o", int'(settled_o), int'(exp_cnt == SETTLE));
    endtask

    // drive at falling edge, update model at rising edge, sample 1 ns later
    task automatic step(input bit lk, input bit hd, input bit mt, input bit cr,
                        input bit tk, input logic [NG-1:0] src);
        bit cause;
        @(negedge clk);
        lock_i = lk; hold_i = hd; mute_i = mt; clr_req_i = cr;
        wclk_tick_i = tk; clk_src_i = src;
        @(posedge clk);
        cause     = !lk || cr;
        exp_fault = cause || (exp_fault && hd);
        exp_dmute = exp_fault || mt;
        if (cause) exp_cnt = 0;
        else if (tk && exp_cnt < SETTLE) exp_cnt++;
        #1;
        check_all();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        clk_src_i = 2'b11;
        lock_i = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R10 values during reset
        check("R10 fault in reset", int'(fault_o), 1);
        check("R10 dmute in reset", int'(dmute_o), 1);
        check("R10 settled in reset", int'(settled_o), 0);
        check("R10 gclk in reset", int'(gclk_o), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10: before lock, fault stays high
        step(0, 0, 0, 0, 1, 2'b11);
        step(0, 0, 0, 0, 1, 2'b10);
        // R2: lock arrives with hold low, fault clears next clock
        step(1, 0, 0, 0, 0, 2'b11);
        check("R2 fault cleared", int'(fault_o), 0);
        check("R6 gclk passes", int'(gclk_o), 3);

        // R8: exactly SETTLE ticks
        for (int i = 0; i < SETTLE - 1; i++) step(1, 0, 0, 0, 1, 2'b01);
        check("R8 not yet settled", int'(settled_o), 0);
        step(1, 0, 0, 0, 0, 2'b01);
        check("R8 idle no tick", int'(settled_o), 0);
        step(1, 0, 0, 0, 1, 2'b01);
        check("R8 settled on last tick", int'(settled_o), 1);
        // R9 saturation
        for (int i = 0; i < 5; i++) step(1, 0, 0, 0, 1, 2'b10);
        check("R9 saturated", int'(settled_o), 1);
        // R9 lock loss clears
        step(0, 0, 0, 0, 1, 2'b11);
        check("R9 cleared on loss", int'(settled_o), 0);
        check("R1 fault on loss", int'(fault_o), 1);

        // R3 sticky hold
        step(1, 1, 0, 0, 0, 2'b11);
        check("R3 held after lock back", int'(fault_o), 1);
        step(1, 1, 0, 0, 0, 2'b11);
        step(0, 0, 0, 0, 0, 2'b11);
        check("R3 cause present keeps fault", int'(fault_o), 1);
        step(1, 0, 0, 0, 0, 2'b11);
        check("R3 released", int'(fault_o), 0);

        // R5 mute without fault
        step(1, 0, 1, 0, 0, 2'b11);
        check("R5 mute silences", int'(dmute_o), 1);
        check("R5 fault unaffected", int'(fault_o), 0);
        check("R5 clocks run", int'(gclk_o), 3);
        step(1, 0, 0, 0, 0, 2'b11);
        check("R5 mute removed", int'(dmute_o), 0);

        // R7 clear-down request
        for (int i = 0; i < SETTLE; i++) step(1, 0, 0, 0, 1, 2'b11);
        check("R7 precondition settled", int'(settled_o), 1);
        step(1, 0, 0, 1, 0, 2'b11);
        check("R7 fault", int'(fault_o), 1);
        check("R7 dmute", int'(dmute_o), 1);
        check("R7 gclk stopped", int'(gclk_o), 0);
        check("R7 settle cleared", int'(settled_o), 0);

        // random mix
        for (int i = 0; i < 4000; i++) begin
            step(($urandom % 24) != 0, ($urandom % 4) == 0, ($urandom % 8) == 0,
                 ($urandom % 64) == 0, ($urandom % 3) == 0, 2'($urandom));
        end

        // R10 reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R10 async reset fault", int'(fault_o), 1);
        check("R10 async reset settled", int'(settled_o), 0);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule